// File: doc/BRIEF.md
# Keyed Watchdog Timer

The block is a watchdog timer for a microcontroller subsystem. A binary counter runs on the system clock from the moment reset is released. When it reaches the time-out count chosen by a two-bit period field, the block raises a one-cycle interrupt request. The counter then wraps to zero and keeps running, so a stalled program sees the interrupt again on every later period.

Software keeps the watchdog quiet by writing a restart key to the command register before the count runs out. Turning the watchdog off takes two writes: clear the enable bit in the mode register, then write the shutdown key to the command register. Writing the enable bit back to one turns it on again, counting from zero. A power-state input stops and zeroes the counter in the two deep low-power states. In the light low-power state, a mode bit decides whether the counter runs or holds its value. An active-low bus-grant input has no effect: counting carries on while another master owns the bus.

Top module: `keyed_wdog`

## Requirements
- R1: After reset the mode register reads 8'h01: bit 0 (enable) is 1, bits 2:1 (period select) are 00, bit 3 (idle-run) is 0. The interrupt is low and counting has started.
- R2: A period select value s sets the time-out to 2^(BASE_SHIFT + 2*s) clock cycles. With the default BASE_SHIFT of 15 this gives 2^15, 2^17, 2^19 and 2^21.
- R3: The interrupt goes high exactly one time-out period of counting cycles after the counter was last zeroed.
- R4: The interrupt is a one-cycle pulse. The counter wraps to zero at time-out and keeps counting, so the pulse recurs every period.
- R5: A write of 8'h4E to the command register (wr_sel = 1) sets the counter to zero.
- R6: A command write of any value other than 8'h4E or 8'hB1 changes nothing.
- R7: A mode register write (wr_sel = 0) stores wr_data bits 3:0. Bits 7:4 of the register read as zero.
- R8: Writing 8'hB1 while the enable bit is 1 is ignored. Clearing the enable bit alone does not stop counting.
- R9: Writing 8'hB1 while the enable bit is 0 turns the watchdog off. The counter is zero and no interrupt occurs.
- R10: While the watchdog is off, writing the mode register with the enable bit set turns it back on, counting from zero.
- R11: With power state 2'b10 or 2'b11 the counter is held at zero. Counting resumes from zero when the state returns to 2'b00 (run).
- R12: In power state 2'b01 the counter holds its value when idle-run is 0 and counts when idle-run is 1.
- R13: The bus-grant input bus_ack_n has no effect on counting or on the interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 mode register, 1 command register |
| wr_data | input | 8 | Write data |
| pwr_mode | input | 2 | Power state: 00 run, 01 idle, 10 sleep, 11 stop |
| bus_ack_n | input | 1 | Active-low bus grant to an external master |
| mode_rd | output | 8 | Mode register read value |
| wdt_irq | output | 1 | Watchdog interrupt pulse |

## Verification
The assertions assume that a write strobe lasts a single cycle per intended access. They also assume that wr_sel and wr_data are stable when wr_en is high, and that pwr_mode changes only between clock edges. The idle-hold property also assumes that software makes no register write while the counter is meant to be frozen. The bench drives every input one nanosecond after a rising edge and pulses wr_en for exactly one edge. It issues no writes while the idle state is active with idle-run off, so all of these assumptions hold for its stimulus. To keep run time short, it shrinks BASE_SHIFT so that the time-out periods are 16, 64, 256 and 1024 cycles.

// File: rtl/wdg_pkg.sv
package wdg_pkg;

    typedef enum logic [1:0] {
        PWR_RUN   = 2'd0,
        PWR_IDLE  = 2'd1,
        PWR_SLEEP = 2'd2,
        PWR_STOP  = 2'd3
    } pwr_e;

    // Mode register layout, msb first: idle-run, period select, enable.
    typedef struct packed {
        logic       idle_run;
        logic [1:0] period;
        logic       enable;
    } mode_t;

    localparam mode_t MODE_RESET = '{idle_run: 1'b0, period: 2'd0, enable: 1'b1};

    localparam logic [7:0] KEY_RESTART  = 8'h4E;
    localparam logic [7:0] KEY_SHUTDOWN = 8'hB1;

    // Control handed from the power gating to the counter core.
    typedef struct packed {
        logic zero;
        logic run;
    } cnt_ctl_t;

    function automatic logic halts_counter(pwr_e m);
        return (m == PWR_SLEEP) || (m == PWR_STOP);
    endfunction

    function automatic logic allows_count(pwr_e m, logic idle_run);
        return (m == PWR_RUN) || ((m == PWR_IDLE) && idle_run);
    endfunction

endpackage

// File: rtl/wdg_ctrl_regs.sv
module wdg_ctrl_regs
    import wdg_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  logic       wr_sel,
    input  logic [7:0] wr_data,
    output mode_t      mode_q,
    output logic       wd_on,
    output logic       kick
);

    logic wr_mode, wr_cmd;
    logic key_restart, key_off_ok, turn_on;

    assign wr_mode = wr_en && !wr_sel;
    assign wr_cmd  = wr_en &&  wr_sel;

    assign key_restart = wr_cmd && (wr_data == KEY_RESTART);
    // Shutdown key only counts once the enable bit has been cleared.
    assign key_off_ok  = wr_cmd && (wr_data == KEY_SHUTDOWN) && !mode_q.enable;
    assign turn_on     = wr_mode && wr_data[0] && !wd_on;

    // Any of these leaves the counter at zero after this edge.
    assign kick = key_restart || key_off_ok || turn_on;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= MODE_RESET;
            wd_on  <= 1'b1;
        end else begin
            if (wr_mode) begin
                mode_q <= mode_t'(wr_data[3:0]);
            end
            if (turn_on) begin
                wd_on <= 1'b1;
            end else if (key_off_ok) begin
                wd_on <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/wdg_tmr_core.sv
module wdg_tmr_core
    import wdg_pkg::*;
#(
    parameter int BASE_SHIFT = 15,
    parameter int PER_STEP   = 2,
    parameter int SEL_W      = 2,
    parameter int CNT_W      = BASE_SHIFT + PER_STEP * ((1 << SEL_W) - 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [SEL_W-1:0] period,
    input  cnt_ctl_t         ctl,
    output logic [CNT_W-1:0] cnt_q,
    output logic             expire
);

    localparam int NSEL = 1 << SEL_W;

    logic [CNT_W-1:0] last_tab [NSEL];
    logic [CNT_W-1:0] last_val;

    // Terminal count for each period select: 2^(BASE_SHIFT+PER_STEP*g) - 1.
    for (genvar g = 0; g < NSEL; g++) begin : g_last
        assign last_tab[g] = CNT_W'((64'd1 << (BASE_SHIFT + PER_STEP * g)) - 64'd1);
    end

    assign last_val = last_tab[period];

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            expire <= 1'b0;
        end else begin
            expire <= 1'b0;
            if (ctl.zero) begin
                cnt_q <= '0;
            end else if (ctl.run) begin
                // >= so a shorter period chosen mid-count still wraps.
                if (cnt_q >= last_val) begin
                    cnt_q  <= '0;
                    expire <= 1'b1;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/keyed_wdog.sv
module keyed_wdog
    import wdg_pkg::*;
#(
    parameter int BASE_SHIFT = 15,
    parameter int PER_STEP   = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  logic       wr_sel,
    input  logic [7:0] wr_data,
    input  logic [1:0] pwr_mode,
    input  logic       bus_ack_n,
    output logic [7:0] mode_rd,
    output logic       wdt_irq
);

    localparam int SEL_W = 2;
    localparam int CNT_W = BASE_SHIFT + PER_STEP * ((1 << SEL_W) - 1);

    mode_t            mode_q;
    logic             wd_on;
    logic             kick;
    cnt_ctl_t         ctl;
    pwr_e             pwr;
    logic [CNT_W-1:0] cnt_q;
    logic             unused_bus_ack;

    // Bus ownership by another master deliberately leaves counting alone.
    assign unused_bus_ack = bus_ack_n;

    assign pwr = pwr_e'(pwr_mode);

    wdg_ctrl_regs u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_data (wr_data),
        .mode_q  (mode_q),
        .wd_on   (wd_on),
        .kick    (kick)
    );

    always_comb begin
        ctl.zero = kick || !wd_on || halts_counter(pwr);
        ctl.run  = wd_on && allows_count(pwr, mode_q.idle_run);
    end

    wdg_tmr_core #(
        .BASE_SHIFT (BASE_SHIFT),
        .PER_STEP   (PER_STEP),
        .SEL_W      (SEL_W),
        .CNT_W      (CNT_W)
    ) u_core (
        .clk    (clk),
        .rst    (rst),
        .period (mode_q.period),
        .ctl    (ctl),
        .cnt_q  (cnt_q),
        .expire (wdt_irq)
    );

    assign mode_rd = {4'b0000, mode_q};

endmodule

// File: rtl/keyed_wdog_chk.sv
module keyed_wdog_chk #(
    parameter int CNT_W = 21
) (
    input logic             clk,
    input logic             rst,
    input logic             wr_en,
    input logic             wr_sel,
    input logic [7:0]       wr_data,
    input logic [1:0]       pwr_mode,
    input logic [7:0]       mode_rd,
    input logic             wdt_irq,
    input logic             wd_on,
    input logic             idle_run,
    input logic [CNT_W-1:0] cnt_q
);

    p_reset_state_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (mode_rd == 8'h01 && !wdt_irq));

    p_irq_single_r4: assert property (@(posedge clk) disable iff (rst)
        wdt_irq |=> !wdt_irq);

    p_restart_zero_r5: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_sel && wr_data == 8'h4E) |=> (cnt_q == '0));

    p_upper_zero_r7: assert property (@(posedge clk) disable iff (rst)
        mode_rd[7:4] == 4'h0);

    p_off_key_ignored_r8: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_sel && wr_data == 8'hB1 && mode_rd[0]) |=> (wd_on == $past(wd_on)));

    p_off_key_taken_r9: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_sel && wr_data == 8'hB1 && !mode_rd[0]) |=> !wd_on);

    p_off_silent_r9: assert property (@(posedge clk) disable iff (rst)
        !wd_on |=> (!wdt_irq && cnt_q == '0));

    p_deep_sleep_r11: assert property (@(posedge clk) disable iff (rst)
        (pwr_mode[1]) |=> (cnt_q == '0 && !wdt_irq));

    p_idle_hold_r12: assert property (@(posedge clk) disable iff (rst)
        (pwr_mode == 2'b01 && !idle_run && !wr_en) |=> $stable(cnt_q));

endmodule

bind keyed_wdog keyed_wdog_chk #(.CNT_W(CNT_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .wr_sel   (wr_sel),
    .wr_data  (wr_data),
    .pwr_mode (pwr_mode),
    .mode_rd  (mode_rd),
    .wdt_irq  (wdt_irq),
    .wd_on    (wd_on),
    .idle_run (mode_q.idle_run),
    .cnt_q    (cnt_q)
);

// File: tb/keyed_wdog_bench.sv
module keyed_wdog_bench;

    localparam int BS = 4;  // periods 16, 64, 256, 1024

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic       wr_sel = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [1:0] pwr_mode = 2'b00;
    logic       bus_ack_n = 1'b1;
    logic [7:0] mode_rd;
    logic       wdt_irq;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    keyed_wdog #(.BASE_SHIFT(BS)) u_keyed_wdog (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_sel    (wr_sel),
        .wr_data   (wr_data),
        .pwr_mode  (pwr_mode),
        .bus_ack_n (bus_ack_n),
        .mode_rd   (mode_rd),
        .wdt_irq   (wdt_irq)
    );

    function automatic int per(int s);
        return 1 << (BS + 2 * s);
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // All tasks start and end 1 ns after a rising edge.
    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic wr(input bit sel, input logic [7:0] d);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(posedge clk); #1;
        wr_en = 1'b0; wr_data = 8'h00;
    endtask

    task automatic wait_irq(input int maxc, output int got);
        got = 0;
        for (int k = 1; k <= maxc; k++) begin
            @(posedge clk); #1;
            if (wdt_irq) begin
                got = k;
                break;
            end
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        tick(3);
        rst = 1'b0;
    endtask

    task automatic t_reset_state();
        int got;
        do_reset();
        check(mode_rd == 8'h01, "R1 mode after reset", mode_rd, 8'h01);
        check(wdt_irq == 1'b0, "R1 irq after reset", wdt_irq, 0);
        wait_irq(2000, got);
        check(got == per(0), "R1 R3 first time-out after reset", got, per(0));
        wait_irq(2000, got);
        check(got == per(0), "R4 recurring time-out with one-cycle pulse", got, per(0));
    endtask

    task automatic t_restart_key();
        int got;
        tick(7);
        wr(1'b1, 8'h4E);
        wait_irq(2000, got);
        check(got == per(0), "R5 restart key zeroes counter", got, per(0));
    endtask

    task automatic t_other_cmds();
        int got;
        wr(1'b1, 8'h4E);
        tick(5);
        wr(1'b1, 8'h4F);
        wr(1'b1, 8'h00);
        wait_irq(2000, got);
        check(got == per(0) - 7, "R6 foreign command values ignored", got, per(0) - 7);
    endtask

    task automatic t_periods();
        int got;
        wr(1'b0, 8'hF3);
        check(mode_rd == 8'h03, "R7 mode readback upper bits zero", mode_rd, 8'h03);
        wr(1'b1, 8'h4E);
        wait_irq(2000, got);
        check(got == per(1), "R2 period select 1", got, per(1));
        wr(1'b0, 8'h05);
        wr(1'b1, 8'h4E);
        wait_irq(2000, got);
        check(got == per(2), "R2 period select 2", got, per(2));
        wr(1'b0, 8'h07);
        wr(1'b1, 8'h4E);
        wait_irq(2000, got);
        check(got == per(3), "R2 period select 3", got, per(3));
        wr(1'b0, 8'h01);
        check(mode_rd == 8'h01, "R7 mode readback", mode_rd, 8'h01);
    endtask

    task automatic t_disable_seq();
        int got;
        wr(1'b1, 8'h4E);
        wr(1'b1, 8'hB1);
        wait_irq(2000, got);
        check(got == per(0) - 1, "R8 shutdown key ignored while enabled", got, per(0) - 1);
        wr(1'b0, 8'h00);
        wr(1'b1, 8'h4E);
        wait_irq(2000, got);
        check(got == per(0), "R8 cleared enable bit alone keeps counting", got, per(0));
        wr(1'b1, 8'hB1);
        wait_irq(300, got);
        check(got == 0, "R9 two-step shutdown silences watchdog", got, 0);
        wr(1'b0, 8'h01);
        wait_irq(2000, got);
        check(got == per(0), "R10 re-enable counts from zero", got, per(0));
    endtask

    task automatic t_deep_sleep(input logic [1:0] st, input string tag);
        int got;
        wr(1'b1, 8'h4E);
        tick(10);
        pwr_mode = st;
        wait_irq(40, got);
        check(got == 0, {"R11 no interrupt in ", tag}, got, 0);
        pwr_mode = 2'b00;
        wait_irq(2000, got);
        check(got == per(0), {"R11 restart from zero after ", tag}, got, per(0));
    endtask

    task automatic t_idle();
        int got;
        wr(1'b1, 8'h4E);
        tick(5);
        pwr_mode = 2'b01;
        wait_irq(50, got);
        check(got == 0, "R12 idle with idle-run 0 holds", got, 0);
        pwr_mode = 2'b00;
        wait_irq(2000, got);
        check(got == per(0) - 5, "R12 count resumes from held value", got, per(0) - 5);
        wr(1'b0, 8'h09);
        check(mode_rd == 8'h09, "R7 idle-run bit readback", mode_rd, 8'h09);
        wr(1'b1, 8'h4E);
        pwr_mode = 2'b01;
        wait_irq(2000, got);
        check(got == per(0), "R12 idle with idle-run 1 counts", got, per(0));
        pwr_mode = 2'b00;
        wr(1'b0, 8'h01);
    endtask

    task automatic t_bus_grant();
        int got;
        wr(1'b1, 8'h4E);
        bus_ack_n = 1'b0;
        wait_irq(2000, got);
        check(got == per(0), "R13 counting during bus grant", got, per(0));
        bus_ack_n = 1'b1;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 150000);
            finish_run();
        end
    end

    initial begin
        t_reset_state();
        t_restart_key();
        t_other_cmds();
        t_periods();
        t_disable_seq();
        t_deep_sleep(2'b10, "sleep");
        t_deep_sleep(2'b11, "stop");
        t_idle();
        t_bus_grant();
        finish_run();
    end

endmodule